// File: doc/BRIEF.md
# Per-Window Time-of-Flight Histogrammer

This block builds one time-of-flight histogram per helicity window. A beam pick-off strobe marks the start of every beam period. Within a period, a hit carries a 7-bit fine-time code that selects one of 128 bins. The block adds the hits bin by bin over every beam period in the window. Only the first hit of a period is accepted. After a period in which a hit was accepted, the whole following period is vetoed to control dead time.

Two counter banks alternate. When the window-boundary strobe arrives, the bank that was filling is frozen and handed to the read port, and the other bank starts from zero. The read port streams one frame per window over valid/ready. A frame is a header word followed by the 128 bin counts in ascending bin order. The output holds `out_valid_o`, `out_data_o` and `out_last_o` steady until `out_ready_i` accepts the word. Words move only on cycles where valid and ready are both high, and the consumer may stall for any number of cycles. If a boundary arrives while a frame is still being streamed, the block flags an overrun and discards the window that just ended.

Top module: `tof_window_histogrammer`

## Requirements
- R1: While reset is held, and in the first cycle after its release, `out_valid_o` and `overrun_o` are low.
- R2: Each accepted hit adds one to the bin selected by `hit_bin_i` (0 to 127) in the filling bank. In a frame, word k+1 holds the count of bin k, zero-extended, for k = 0 to 127.
- R3: A bin count never wraps. Once it reaches its maximum value (all ones in CNT_W bits), further hits leave it at that value.
- R4: When a hit has been accepted in a beam period, no hit is accepted anywhere in the next period. A hit in the same cycle as `start_i` belongs to the period that is ending.
- R5: Within a beam period, only the first hit that is not vetoed is accepted. Later hits in that period change no count.
- R6: On `win_end_i`, a hit in the same cycle is counted in the ending window, and the next window starts with every bin at zero.
- R7: The header word carries the helicity bit sampled in the boundary cycle at the MSB. Below it are SEQ_W bits of window sequence number, and in the low CNT_W bits is the ending window's veto count. The sequence number starts at 0 after reset and advances at every boundary, including an overrun.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the valid, data and last outputs stay unchanged. `out_last_o` is high only on the word for bin 127. Once the frame ends, `out_valid_o` falls.
- R9: A boundary that arrives while a frame is being streamed, including the cycle in which its last word is accepted, raises `overrun_o` for one cycle in the following cycle. The ending window is then discarded and the frame in progress continues unchanged.
- R10: The veto count advances by one at each `start_i` that opens a vetoed period and saturates at all ones. A vetoed period opened in the boundary cycle counts toward the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Beam pick-off strobe, opens a new beam period |
| hit_valid_i | input | 1 | A hit is present this cycle |
| hit_bin_i | input | BIN_W | Fine-time bin code of the hit |
| win_end_i | input | 1 | Helicity window boundary strobe |
| helicity_i | input | 1 | Helicity of the current window |
| out_valid_o | output | 1 | Frame word available |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_data_o | output | 1+SEQ_W+CNT_W | Header or bin count |
| out_last_o | output | 1 | Final word of the frame |
| overrun_o | output | 1 | Boundary arrived while a frame was being streamed |

## Verification
Two events can land in the same cycle. A window boundary can coincide with the acceptance of a frame's last word, which must count as an overrun. A hit or a veto-opening start strobe can coincide with a boundary, and these must be split between the ending and the new window. The bench provokes the first by streaming with ready held high until the last word is pending and then asserting the boundary with it. The second arises repeatedly during random traffic and during a window with a hit on every cycle. The frame contents, the overrun pulse and the next frame's header are compared against a cycle model built from the requirements.

// File: rtl/tofh_pkg.sv
package tofh_pkg;
  localparam int TOFH_BIN_W = 7;
  localparam int TOFH_CNT_W = 24;
  localparam int TOFH_SEQ_W = 8;
  localparam int TOFH_BANKS = 2;
  typedef logic bank_sel_t;
endpackage

// File: rtl/tofh_period_gate.sv
module tofh_period_gate #(
  parameter int CNT_W = tofh_pkg::TOFH_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             hit_i,
  input  logic             win_end_i,
  output logic             accept_o,
  output logic [CNT_W-1:0] veto_cnt_o
);
  localparam logic [CNT_W-1:0] VMAX = '1;

  logic seen_q, veto_q, open_veto;
  logic [CNT_W-1:0] vcnt_q;

  assign accept_o   = hit_i & ~veto_q & ~seen_q;
  assign open_veto  = start_i & (seen_q | accept_o);
  assign veto_cnt_o = vcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      veto_q <= 1'b0;
    end else if (start_i) begin
      veto_q <= open_veto;
      seen_q <= 1'b0;
    end else if (accept_o) begin
      seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          vcnt_q <= '0;
    else if (win_end_i)  vcnt_q <= CNT_W'(open_veto);
    else if (open_veto && vcnt_q != VMAX) vcnt_q <= vcnt_q + 1'b1;
  end

  // R4: accepted hit on a start edge -> next period is vetoed
  a_r4_veto_next: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && accept_o) |=> !accept_o);
  // R5: one accepted hit per period
  a_r5_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !start_i) |=> !accept_o);
  // R10: veto count holds at saturation inside a window
  a_r10_veto_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt_q == VMAX && !win_end_i) |=> vcnt_q == VMAX);
endmodule

// File: rtl/tofh_bank_store.sv
module tofh_bank_store #(
  parameter int BIN_W = tofh_pkg::TOFH_BIN_W,
  parameter int CNT_W = tofh_pkg::TOFH_CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tofh_pkg::bank_sel_t acc_sel_i,
  input  logic                wr_en_i,
  input  logic [BIN_W-1:0]    wr_bin_i,
  input  logic                clr_en_i,
  input  tofh_pkg::bank_sel_t clr_sel_i,
  input  tofh_pkg::bank_sel_t rd_sel_i,
  input  logic [BIN_W-1:0]    rd_bin_i,
  output logic [CNT_W-1:0]    rd_cnt_o
);
  localparam int NBINS  = 1 << BIN_W;
  localparam int NBANKS = tofh_pkg::TOFH_BANKS;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q [NBANKS][NBINS];
  logic [NBINS-1:0] vld_w [NBANKS];
  logic [CNT_W-1:0] cur;

  // per-bank "bin has been written" flags make a whole-bank clear one cycle
  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [NBINS-1:0] vld_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else begin
        if (wr_en_i && acc_sel_i == b[0]) vld_q[wr_bin_i] <= 1'b1;
        if (clr_en_i && clr_sel_i == b[0]) vld_q <= '0;
      end
    end
    assign vld_w[b] = vld_q;
  end

  assign cur      = vld_w[acc_sel_i][wr_bin_i] ? cnt_q[acc_sel_i][wr_bin_i] : '0;
  assign rd_cnt_o = vld_w[rd_sel_i][rd_bin_i] ? cnt_q[rd_sel_i][rd_bin_i] : '0;

  always_ff @(posedge clk) begin
    if (wr_en_i) cnt_q[acc_sel_i][wr_bin_i] <= (cur == CMAX) ? CMAX : cur + 1'b1;
  end

  // R3: saturated bin stays at maximum after another hit
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clr_en_i && cur == CMAX)
      |=> cnt_q[$past(acc_sel_i)][$past(wr_bin_i)] == CMAX);
endmodule

// File: rtl/tofh_frame_reader.sv
module tofh_frame_reader #(
  parameter int BIN_W  = tofh_pkg::TOFH_BIN_W,
  parameter int CNT_W  = tofh_pkg::TOFH_CNT_W,
  parameter int DATA_W = 1 + tofh_pkg::TOFH_SEQ_W + tofh_pkg::TOFH_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] hdr_i,
  input  logic [CNT_W-1:0]  bin_cnt_i,
  output logic [BIN_W-1:0]  rd_bin_o,
  output logic              busy_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_last_o
);
  localparam int NBINS = 1 << BIN_W;
  localparam int IDX_W = $clog2(NBINS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBINS);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] hdr_q;

  assign busy_o    = active_q;
  assign m_valid_o = active_q;
  assign m_last_o  = active_q && idx_q == LAST_IDX;
  assign rd_bin_o  = BIN_W'(idx_q - 1'b1);
  assign m_data_o  = (idx_q == '0) ? hdr_q
                                   : {{(DATA_W-CNT_W){1'b0}}, bin_cnt_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      hdr_q    <= '0;
    end else if (launch_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      hdr_q    <= hdr_i;
    end else if (active_q && m_ready_i) begin
      if (idx_q == LAST_IDX) active_q <= 1'b0;
      else                   idx_q    <= idx_q + 1'b1;
    end
  end

  // R8: stalled word is held
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i)
      |=> m_valid_o && $stable(m_data_o) && $stable(m_last_o));
  // R9: a new frame is only launched into an idle reader
  a_r9_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> !m_valid_o);
endmodule

// File: rtl/tof_window_histogrammer.sv
module tof_window_histogrammer #(
  parameter int BIN_W = tofh_pkg::TOFH_BIN_W,
  parameter int CNT_W = tofh_pkg::TOFH_CNT_W,
  parameter int SEQ_W = tofh_pkg::TOFH_SEQ_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   hit_valid_i,
  input  logic [BIN_W-1:0]       hit_bin_i,
  input  logic                   win_end_i,
  input  logic                   helicity_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [SEQ_W+CNT_W:0]   out_data_o,
  output logic                   out_last_o,
  output logic                   overrun_o
);
  localparam int DATA_W = 1 + SEQ_W + CNT_W;

  tofh_pkg::bank_sel_t acc_sel_q;
  logic [SEQ_W-1:0]    seq_q;
  logic                ov_q, accept, busy, launch;
  logic [CNT_W-1:0]    veto_cnt, rd_cnt;
  logic [BIN_W-1:0]    rd_bin;
  logic [DATA_W-1:0]   hdr;

  assign launch    = win_end_i & ~busy;
  assign hdr       = {helicity_i, seq_q, veto_cnt};
  assign overrun_o = ov_q;

  tofh_period_gate #(.CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hit_i(hit_valid_i),
    .win_end_i(win_end_i), .accept_o(accept), .veto_cnt_o(veto_cnt));

  tofh_bank_store #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .acc_sel_i(acc_sel_q), .wr_en_i(accept),
    .wr_bin_i(hit_bin_i), .clr_en_i(win_end_i),
    .clr_sel_i(busy ? acc_sel_q : ~acc_sel_q),
    .rd_sel_i(~acc_sel_q), .rd_bin_i(rd_bin), .rd_cnt_o(rd_cnt));

  tofh_frame_reader #(.BIN_W(BIN_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .hdr_i(hdr),
    .bin_cnt_i(rd_cnt), .rd_bin_o(rd_bin), .busy_o(busy),
    .m_valid_o(out_valid_o), .m_ready_i(out_ready_i),
    .m_data_o(out_data_o), .m_last_o(out_last_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_sel_q <= 1'b0;
      seq_q     <= '0;
      ov_q      <= 1'b0;
    end else begin
      ov_q <= win_end_i & busy;
      if (win_end_i) seq_q <= seq_q + 1'b1;
      if (launch)    acc_sel_q <= ~acc_sel_q;
    end
  end

  // R9: overrun only follows a boundary met by a busy read port
  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(win_end_i) && $past(out_valid_o));
  // R6: a clean boundary starts streaming in the next cycle
  a_r6_frame_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_i && !out_valid_o) |=> out_valid_o && !overrun_o);
endmodule

// File: tb/tof_window_histogrammer_test.sv
module tof_window_histogrammer_test;
  localparam int BIN_W = 7, CNT_W = 6, SEQ_W = 4;
  localparam int NB = 128, PER = 4, MAXC = 63, SEQ_MOD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, hit_valid_i = 0, win_end_i = 0, helicity_i = 0, out_ready_i = 0;
  logic [BIN_W-1:0] hit_bin_i = '0;
  logic out_valid_o, out_last_o, overrun_o;
  logic [SEQ_W+CNT_W:0] out_data_o;

  always #10 clk = ~clk;

  tof_window_histogrammer #(.BIN_W(BIN_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hit_valid_i(hit_valid_i),
    .hit_bin_i(hit_bin_i), .win_end_i(win_end_i), .helicity_i(helicity_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .out_last_o(out_last_o), .overrun_o(overrun_o));

  int checks = 0, fails = 0, cyc = 0;
  int acc [NB];
  int expw [NB+1];
  bit pending = 0, seen = 0, veto = 0, hel = 0, exp_ov = 0;
  int ridx = 0, vc = 0, seq = 0, ph = 0;

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int hdr_word(bit h, int s, int v);
    return (int'(h) << (SEQ_W + CNT_W)) | ((s % SEQ_MOD) << CNT_W) | v;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic tick(bit h, int b, bit we, int rdy);
    bit st, rb, busy, ok_hit, nv;
    @(negedge clk);
    chk(overrun_o == exp_ov, "R9 overrun flag", overrun_o, exp_ov);
    chk(out_valid_o == pending, "R8 valid level", out_valid_o, pending);
    st = (ph == 0);
    ph = (ph + 1) % PER;
    rb = (($urandom % 100) < rdy);
    start_i = st; hit_valid_i = h; hit_bin_i = 7'(b);
    win_end_i = we; helicity_i = hel; out_ready_i = rb;
    busy = pending;
    if (pending && rb) begin
      if (ridx == 0) chk(32'(out_data_o) == expw[0], "R7 R10 header", out_data_o, expw[0]);
      else chk(32'(out_data_o) == expw[ridx], "R2 R3 R4 R5 R6 bin count", out_data_o, expw[ridx]);
      chk(out_last_o == (ridx == NB), "R8 last flag", out_last_o, ridx == NB);
      ridx++;
      if (ridx > NB) pending = 0;
    end
    ok_hit = h && !veto && !seen;
    if (ok_hit && acc[b] < MAXC) acc[b]++;
    exp_ov = 0;
    if (we) begin
      if (!busy) begin
        expw[0] = hdr_word(hel, seq, vc);
        for (int i = 0; i < NB; i++) expw[i+1] = acc[i];
        pending = 1; ridx = 0;
      end else exp_ov = 1;
      for (int i = 0; i < NB; i++) acc[i] = 0;
      vc = 0;
      seq = (seq + 1) % SEQ_MOD;
    end
    if (st) begin
      nv = seen | ok_hit;
      if (nv && vc < MAXC) vc++;
      veto = nv; seen = 0;
    end else if (ok_hit) seen = 1;
  endtask

  task automatic run_window(int n, int hit_pct, int rdy);
    for (int i = 0; i < n; i++)
      tick(($urandom % 100) < hit_pct, $urandom % NB, 1'b0, rdy);
    tick(($urandom % 100) < hit_pct, $urandom % NB, 1'b1, rdy);
    hel = $urandom % 2;
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd7211);
    for (int i = 0; i < NB; i++) acc[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R1 valid in reset", out_valid_o, 0);
    chk(overrun_o == 1'b0, "R1 overrun in reset", overrun_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R1 valid after reset", out_valid_o, 0);
    chk(overrun_o == 1'b0, "R1 overrun after reset", overrun_o, 0);
    // random traffic windows
    run_window(300, 40, 100);
    run_window(400, 70, 60);
    // hit on every cycle to one bin: saturation of bin and veto count (R3, R10)
    for (int i = 0; i < 600; i++) tick(1'b1, 9, 1'b0, 80);
    tick(1'b1, 9, 1'b1, 80);
    hel = ~hel;
    // R9: boundary while previous frame stalled
    run_window(40, 50, 0);
    run_window(300, 50, 100);
    // R9: boundary on the cycle the last word is accepted
    while (!(pending && ridx == NB)) tick(($urandom % 100) < 50, $urandom % NB, 1'b0, 100);
    tick(1'b1, 3, 1'b1, 100);
    while (pending) tick(($urandom % 100) < 50, $urandom % NB, 1'b0, 100);
    run_window(250, 90, 70);
    while (pending) tick(1'b0, 0, 1'b0, 50);
    tick(1'b0, 0, 1'b0, 100);
    finish_run();
  end
endmodule